// File: doc/BRIEF.md
# Pipelined Self-Routing Butterfly Network

This block moves fixed-format packets from N requester ports to N memory-bank ports through a stack of 2x2 switch stages. There are log2(N) stages. Each stage is registered, so a packet advances one stage per clock and many packets can be in flight at once. Every switch reads one destination bit from the packet itself and steers the packet on that bit. No route is computed ahead of time and no setup phase is needed.

Two packets that arrive at the same switch in the same cycle may want the same output. A round-robin pointer on that output then picks which one moves forward. The other one waits at its input with ready held low. Each switch output ends in a small first-in-first-out queue, so a stall does not spread upstream at once. Traffic flows one way only, from requesters to banks. Every port handshakes with valid/ready. A packet carries its destination, the number of the port that sent it, and a data word.

Top module: `pipe_route_net`

## Requirements
- R1: After reset every `out_valid` bit is 0, and every `in_ready` bit is 1 while no input is valid.
- R2: A packet accepted on input port p with destination field d (`in_dest[p*A +: A]`, A = log2(N)) leaves on output port d. Its data is unchanged, and `out_src[d*A +: A]` equals p.
- R3: With no other traffic and every `out_ready` high, a packet accepted in cycle c is presented at its output in cycle c+log2(N).
- R4: One input can stream to one output at one packet per cycle with no gaps. Each packet of the stream keeps the latency of R3.
- R5: Packets with the same source and the same destination leave in the order they were accepted.
- R6: When two inputs of a switch want the same output in the same cycle, exactly one of them is ready. Under sustained contention the round-robin pointer alternates the grants, so the output carries the two sources in turn.
- R7: While `out_ready` is low, a presented packet stays valid with its data unchanged. A blocked network lowers `in_ready`, and it accepts no more packets than its queue space on the blocked paths. With N = 8, all-to-one traffic fills 14 queue slots.
- R8: Every accepted packet is delivered exactly once. Nothing is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per-requester packet valid |
| in_ready | output | N | Per-requester packet accepted when high with valid |
| in_dest | input | N*A | Per-requester destination port number |
| in_data | input | N*DATA_W | Per-requester data word |
| out_valid | output | N | Per-bank packet valid |
| out_ready | input | N | Per-bank consumer ready |
| out_src | output | N*A | Per-bank number of the sending requester |
| out_data | output | N*DATA_W | Per-bank data word |

## Verification
Two things can fall in the same cycle at one switch. The switch may have to settle a clash between its two inputs while its output queue is also being held full by a stalled bank. The bench provokes this by sending many-to-one and random traffic while toggling `out_ready` at random, and by filling the whole tree leading to one bank. The result is judged by a scoreboard with one queue per source and destination pair, which checks order and integrity. Hold-stability checks at the stalled outputs and the exact fill count of the blocked tree complete the judgement.

// File: rtl/pipe_route_pkg.sv
package pipe_route_pkg;
  // Lower line of the pair that a stage switch k joins: insert a 0 at bit bp.
  function automatic int low_line(input int k, input int bp);
    return ((k >> bp) << (bp + 1)) | (k & ((1 << bp) - 1));
  endfunction

  // Upper line of the same pair.
  function automatic int high_line(input int k, input int bp);
    return low_line(k, bp) | (1 << bp);
  endfunction

  // Next queue pointer with wrap at depth.
  function automatic int next_ptr(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/pipe_route_fifo.sv
module pipe_route_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         room,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign room       = (cnt < CNT_W'(DEPTH));
  assign head_valid = (cnt != '0);
  assign head_data  = mem[rd_ptr];
  assign do_push    = push && room;
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr <= PTR_W'(pipe_route_pkg::next_ptr(int'(wr_ptr), DEPTH));
      end
      if (do_pop)
        rd_ptr <= PTR_W'(pipe_route_pkg::next_ptr(int'(rd_ptr), DEPTH));
      cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/pipe_route_switch.sv
module pipe_route_switch #(
  parameter int PKT_W = 38,
  parameter int DATA_W = 32,
  parameter int BIT_POS = 0,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            in_v,
  input  logic [1:0][PKT_W-1:0] in_d,
  output logic [1:0]            in_r,
  output logic [1:0]            out_v,
  output logic [1:0][PKT_W-1:0] out_d,
  input  logic [1:0]            out_r
);
  logic [1:0] want;      // output each input asks for
  logic [1:0] clash;     // input i meets a rival for the same output
  logic [1:0] room;
  logic [1:0] push;
  logic [1:0] pick;      // which input feeds output j this cycle
  logic [1:0] favour;    // round-robin pointer per output

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      want[i]  = in_d[i][DATA_W + BIT_POS];
      clash[i] = in_v[1 - i] && (want[1 - i] == want[i]);
      in_r[i]  = room[want[i]] && (!clash[i] || (favour[want[i]] == 1'(i)));
    end
    for (int j = 0; j < 2; j++) begin
      pick[j] = in_v[1] && in_r[1] && (want[1] == 1'(j));
      push[j] = pick[j] || (in_v[0] && in_r[0] && (want[0] == 1'(j)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      favour <= '0;
    end else begin
      for (int j = 0; j < 2; j++)
        if (push[j]) favour[j] <= ~pick[j];
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_out
    pipe_route_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[j]),
      .push_data (in_d[pick[j]]),
      .room      (room[j]),
      .pop       (out_r[j]),
      .head_valid(out_v[j]),
      .head_data (out_d[j])
    );
  end
endmodule

// File: rtl/pipe_route_net.sv
module pipe_route_net #(
  parameter int N_PORTS = 8,
  parameter int DATA_W = 32,
  parameter int FIFO_DEPTH = 2,
  localparam int ADDR_W = $clog2(N_PORTS),
  localparam int STAGES = ADDR_W,
  localparam int PKT_W = 2 * ADDR_W + DATA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        in_valid,
  output logic [N_PORTS-1:0]        in_ready,
  input  logic [N_PORTS*ADDR_W-1:0] in_dest,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  output logic [N_PORTS-1:0]        out_valid,
  input  logic [N_PORTS-1:0]        out_ready,
  output logic [N_PORTS*ADDR_W-1:0] out_src,
  output logic [N_PORTS*DATA_W-1:0] out_data
);
  // Packet layout: {source, destination, data}; line index at level s.
  logic             ln_v [STAGES+1][N_PORTS];
  logic             ln_r [STAGES+1][N_PORTS];
  logic [PKT_W-1:0] ln_d [STAGES+1][N_PORTS];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_edge
    assign ln_v[0][p] = in_valid[p];
    assign ln_d[0][p] = {ADDR_W'(p), in_dest[p*ADDR_W +: ADDR_W], in_data[p*DATA_W +: DATA_W]};
    assign in_ready[p] = ln_r[0][p];
    assign out_valid[p] = ln_v[STAGES][p];
    assign out_src[p*ADDR_W +: ADDR_W] = ln_d[STAGES][p][PKT_W-1 -: ADDR_W];
    assign out_data[p*DATA_W +: DATA_W] = ln_d[STAGES][p][DATA_W-1:0];
    assign ln_r[STAGES][p] = out_ready[p];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int BP = ADDR_W - 1 - s;
    for (genvar k = 0; k < N_PORTS / 2; k++) begin : g_sw
      localparam int LO = pipe_route_pkg::low_line(k, BP);
      localparam int HI = pipe_route_pkg::high_line(k, BP);
      logic [1:0]            iv, ir, ov, orr;
      logic [1:0][PKT_W-1:0] id, od;

      assign iv    = {ln_v[s][HI], ln_v[s][LO]};
      assign id[0] = ln_d[s][LO];
      assign id[1] = ln_d[s][HI];
      assign ln_r[s][LO] = ir[0];
      assign ln_r[s][HI] = ir[1];
      assign ln_v[s+1][LO] = ov[0];
      assign ln_v[s+1][HI] = ov[1];
      assign ln_d[s+1][LO] = od[0];
      assign ln_d[s+1][HI] = od[1];
      assign orr = {ln_r[s+1][HI], ln_r[s+1][LO]};

      pipe_route_switch #(
        .PKT_W(PKT_W), .DATA_W(DATA_W), .BIT_POS(BP), .FIFO_DEPTH(FIFO_DEPTH)
      ) u_sw (
        .clk  (clk),
        .rst_n(rst_n),
        .in_v (iv),
        .in_d (id),
        .in_r (ir),
        .out_v(ov),
        .out_d(od),
        .out_r(orr)
      );
    end
  end
endmodule

// File: rtl/pipe_route_chk.sv
module pipe_route_chk #(
  parameter int N_PORTS = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(N_PORTS),
  localparam int STAGES = ADDR_W,
  localparam int PKT_W = 2 * ADDR_W + DATA_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PORTS-1:0] out_valid,
  input logic [N_PORTS-1:0] out_ready,
  input logic               ln_v [STAGES+1][N_PORTS],
  input logic               ln_r [STAGES+1][N_PORTS],
  input logic [PKT_W-1:0]   ln_d [STAGES+1][N_PORTS]
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_valid == '0)); // R1

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    AST_DEST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ln_v[STAGES][p] |-> (ln_d[STAGES][p][DATA_W +: ADDR_W] == ADDR_W'(p))); // R2
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_lvl
    localparam int BP = ADDR_W - s;
    for (genvar p = 0; p < N_PORTS; p++) begin : g_ln
      AST_STAGE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        ln_v[s][p] |-> (ln_d[s][p][DATA_W + BP] == 1'((p >> BP) & 1))); // R2
      AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_v[s][p] && !ln_r[s][p]) |=> (ln_v[s][p] && $stable(ln_d[s][p]))); // R7
    end
  end
endmodule

bind pipe_route_net pipe_route_chk #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/pipe_route_net_test.sv
module pipe_route_net_test;
  localparam int N  = 8;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int S  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      in_valid = '0;
  logic [N-1:0]      in_ready;
  logic [N*AW-1:0]   in_dest = '0;
  logic [N*DW-1:0]   in_data = '0;
  logic [N-1:0]      out_valid;
  logic [N-1:0]      out_ready = '0;
  logic [N*AW-1:0]   out_src;
  logic [N*DW-1:0]   out_data;

  pipe_route_net #(.N_PORTS(N), .DATA_W(DW)) uut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  bit lat_mode = 0;
  int rdy_mode = 1;            // 0 low, 1 high, 2 random
  logic [AW+DW-1:0] gq [N][$]; // pending stimulus {dest, data}
  logic [63:0]      sb [N*N][$]; // expected {accept cycle, data}
  bit               stalled [N];
  logic [AW+DW-1:0] stall_pkt [N];
  int               seq3 [$]; // sources seen on bank 3

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit probe);
    @(negedge clk);
    cyc++;
    for (int p = 0; p < N; p++) begin
      in_valid[p] = (gq[p].size() > 0);
      if (gq[p].size() > 0) {in_dest[p*AW +: AW], in_data[p*DW +: DW]} = gq[p][0];
    end
    for (int q = 0; q < N; q++)
      out_ready[q] = (rdy_mode == 2) ? 1'($urandom_range(0, 1)) : (rdy_mode == 1);
    #1;
    if (probe) // R6 one of two rivals ready
      check(32'(in_ready[0]) + 32'(in_ready[4]) == 1, "R6", "rivals ready", 32'(in_ready[0]) + 32'(in_ready[4]), 1);
    for (int q = 0; q < N; q++) begin
      if (stalled[q])
        check(out_valid[q] && {out_src[q*AW +: AW], out_data[q*DW +: DW]} == stall_pkt[q],
              "R7", "stalled output held", longint'(out_data[q*DW +: DW]), longint'(stall_pkt[q][DW-1:0]));
      if (out_valid[q] && out_ready[q]) begin
        int src = int'(out_src[q*AW +: AW]);
        if (q == 3) seq3.push_back(src);
        if (sb[src*N+q].size() == 0) begin
          check(0, "R2", "unexpected packet at bank", q, -1);
        end else begin
          logic [63:0] e = sb[src*N+q].pop_front();
          check(out_data[q*DW +: DW] == e[31:0], "R5", "data order per pair", longint'(out_data[q*DW +: DW]), longint'(e[31:0]));
          if (lat_mode) check(cyc - int'(e[63:32]) == S, "R3", "latency", cyc - int'(e[63:32]), S);
        end
      end
      stalled[q]   = out_valid[q] && !out_ready[q];
      stall_pkt[q] = {out_src[q*AW +: AW], out_data[q*DW +: DW]};
    end
    for (int p = 0; p < N; p++)
      if (in_valid[p] && in_ready[p]) begin
        int d = int'(in_dest[p*AW +: AW]);
        sb[p*N+d].push_back({32'(cyc), in_data[p*DW +: DW]});
        void'(gq[p].pop_front());
      end
  endtask

  function automatic int pending();
    int n = 0;
    for (int i = 0; i < N*N; i++) n += sb[i].size();
    for (int p = 0; p < N; p++) n += gq[p].size();
    return n;
  endfunction

  task automatic drain();
    for (int i = 0; i < 2000 && pending() > 0; i++) step(0);
    check(pending() == 0, "R8", "all packets delivered", pending(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == '0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == '1, "R1", "in_ready after reset", longint'(in_ready), 255);

    // R3 single isolated packet
    lat_mode = 1; rdy_mode = 1;
    gq[2].push_back({3'd5, 32'hA5A5_0001});
    drain();

    // R4 back-to-back stream from port 1 to bank 6
    for (int i = 0; i < 10; i++) gq[1].push_back({3'd6, 32'h1000 + 32'(i)});
    drain();
    lat_mode = 0;

    // R2 shifted permutation, several rounds
    for (int i = 0; i < 4; i++)
      for (int p = 0; p < N; p++) gq[p].push_back({3'((p + 3) % N), 32'h2000 + 32'(p*16 + i)});
    drain();

    // R6 ports 0 and 4 meet at the first stage on their way to bank 3
    seq3.delete();
    for (int i = 0; i < 6; i++) begin
      gq[0].push_back({3'd3, 32'h3000 + 32'(i)});
      gq[4].push_back({3'd3, 32'h3400 + 32'(i)});
    end
    step(1);
    drain();
    check(seq3.size() == 12, "R6", "contended packets out", seq3.size(), 12);
    for (int i = 1; i < seq3.size(); i++)
      check(seq3[i] != seq3[i-1], "R6", "round-robin alternation", seq3[i], 4 - seq3[i-1]);

    // R7 fill the tree to bank 0 with the banks stalled
    rdy_mode = 0;
    for (int p = 0; p < N; p++)
      for (int i = 0; i < 6; i++) gq[p].push_back({3'd0, 32'h4000 + 32'(p*16 + i)});
    for (int i = 0; i < 40; i++) step(0);
    begin
      int held = 0;
      for (int i = 0; i < N*N; i++) held += sb[i].size();
      check(held == 14, "R7", "packets held in blocked tree", held, 14);
    end
    check(in_ready == '0, "R7", "inputs blocked", longint'(in_ready), 0);
    rdy_mode = 1;
    drain();

    // R5 R8 random traffic with random bank stalls
    rdy_mode = 2;
    for (int i = 0; i < 400; i++)
      gq[$urandom_range(0, N-1)].push_back({3'($urandom_range(0, N-1)), 32'h5000_0000 + 32'(i)});
    drain();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule